// File: doc/BRIEF.md
# Cascaded Baud Tick Divider Chain

This block times a serial protocol engine without making any derived clock. Every stage runs on the core clock. Each stage passes a one-cycle enable strobe to the next stage.

The chain starts from a reference tick. A protocol stage either forwards every reference tick or every second one. A 10-bit programmable divider follows it. A two-bit source select then picks one of four rates to act as the sample clock:
- the divider output,
- the protocol tick,
- an external serial-clock tick,
- the raw reference tick.

The chosen rate passes through a 2-bit pre-divider and then a 5-bit denominator divider. The denominator's output is the bit-sample tick that the receiver and transmitter step on. In UART use, keep the denominator at 15 or below; a value above 4 gives reliable mid-bit sampling.

A 10-bit measurement counter sits beside the chain. It counts either protocol ticks or divider ticks and is used to time incoming edges.

Each stage's strobe is brought out, so a protocol engine can tap the rate it needs. When a stage's ratio is zero, its input strobe passes through in the same cycle. A newly written ratio waits until the current division cycle ends, so a count in progress is never cut short.

Top module: `baud_div_chain`

## Requirements
- R1: While `chain_en` is low, every tick output stays low and `meas_count` reads zero. Raising `chain_en` again starts every stage from a count of zero.
- R2: With `half_sel` = 0, `proto_tick` repeats every `ref_tick`. With `half_sel` = 1, it fires on the 2nd, 4th, 6th … reference tick after enable.
- R3: `div_tick` fires on every (`div_ratio`+1)-th protocol tick, starting with the (`div_ratio`+1)-th.
- R4: `samp_sel` picks the sample source: 0 = `div_tick`, 1 = `proto_tick`, 2 = `sclk_tick`, 3 = `ref_tick`. `samp_tick` reflects the chosen strobe in the same cycle.
- R5: `pre_tick` fires on every (`pre_ratio`+1)-th sample tick.
- R6: `bit_tick` fires on every (`den_ratio`+1)-th pre-divided tick.
- R7: A ratio changed in the middle of a count takes effect only after that stage's next output tick.
- R8: A stage whose ratio is zero passes its input strobe to its output in the same core cycle.
- R9: While `meas_en` is high, `meas_count` advances by one, one cycle after each counted tick, wrapping from 1023 to 0. The counted tick is a protocol tick when `meas_sel` = 0 and a divider tick when `meas_sel` = 1. While `meas_en` is low, the count is cleared.
- R10: A stage output is high only in a cycle in which that stage's input strobe is also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chain_en | input | 1 | Chain enable; low clears all counters and silences ticks |
| ref_tick | input | 1 | Reference rate strobe |
| sclk_tick | input | 1 | External serial-clock strobe |
| half_sel | input | 1 | 1 halves the reference rate for the protocol stage |
| div_ratio | input | 10 | Divider ratio minus one |
| samp_sel | input | 2 | Sample source select |
| pre_ratio | input | 2 | Pre-divider ratio minus one |
| den_ratio | input | 5 | Denominator ratio minus one |
| meas_en | input | 1 | Measurement counter enable |
| meas_sel | input | 1 | Measurement source: 0 protocol tick, 1 divider tick |
| proto_tick | output | 1 | Protocol stage strobe |
| div_tick | output | 1 | Divider stage strobe |
| samp_tick | output | 1 | Selected sample strobe |
| pre_tick | output | 1 | Pre-divider strobe |
| bit_tick | output | 1 | Bit-sample strobe |
| meas_count | output | 10 | Measurement counter value |

## Verification
A stuck or misloaded stage counter shows as a wrong tick count at that stage's output. The error then carries into every stage downstream of it. It appears within one full division cycle of the faulty stage, which is at most ratio+1 input strobes.

A ratio register that reloads too early shows up as a short gap at the first tick after a change. A measurement counter that counts the wrong source drifts away from the expected value by the end of the first run.

// File: rtl/baud_chain_pkg.sv
package baud_chain_pkg;
  typedef enum logic [1:0] {
    SRC_DIV  = 2'd0,
    SRC_PROT = 2'd1,
    SRC_SCLK = 2'd2,
    SRC_REF  = 2'd3
  } samp_src_e;

  // choose which strobe acts as the sample clock
  function automatic logic pick_sample(input samp_src_e s, input logic d,
                                       input logic p, input logic x,
                                       input logic r);
    logic o;
    case (s)
      SRC_DIV:  o = d;
      SRC_PROT: o = p;
      SRC_SCLK: o = x;
      default:  o = r;
    endcase
    return o;
  endfunction

  // number of input strobes consumed per output strobe
  function automatic int strobes_per_out(input int ratio);
    return ratio + 1;
  endfunction
endpackage

// File: rtl/baud_tick_divider.sv
module baud_tick_divider #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         in_tick,
  input  logic [W-1:0] ratio,
  output logic         out_tick
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] act_q;
  logic         term;

  assign term     = en && in_tick && (cnt_q == act_q);
  assign out_tick = term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= '0;
    end else if (!en) begin
      cnt_q <= '0;
      act_q <= ratio;
    end else if (in_tick) begin
      if (term) begin
        cnt_q <= '0;
        act_q <= ratio;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R10
  out_only_on_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_tick |-> in_tick);
  // R7
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !out_tick) |=> $stable(act_q));
  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q <= act_q));
endmodule

// File: rtl/baud_meas_counter.sv
module baud_meas_counter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         src_sel,
  input  logic         prot_tick,
  input  logic         div_tick,
  output logic [W-1:0] count
);
  logic step;

  assign step = en && (src_sel ? div_tick : prot_tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (!en)  count <= '0;
    else if (step) count <= count + 1'b1;
  end

  // R9
  meas_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (count == W'($past(count) + 1'b1)));
  // R9
  meas_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (count == '0));
endmodule

// File: rtl/baud_div_chain.sv
module baud_div_chain #(
  parameter int DIV_W  = 10,
  parameter int PRE_W  = 2,
  parameter int DEN_W  = 5,
  parameter int MEAS_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chain_en,
  input  logic              ref_tick,
  input  logic              sclk_tick,
  input  logic              half_sel,
  input  logic [DIV_W-1:0]  div_ratio,
  input  logic [1:0]        samp_sel,
  input  logic [PRE_W-1:0]  pre_ratio,
  input  logic [DEN_W-1:0]  den_ratio,
  input  logic              meas_en,
  input  logic              meas_sel,
  output logic              proto_tick,
  output logic              div_tick,
  output logic              samp_tick,
  output logic              pre_tick,
  output logic              bit_tick,
  output logic [MEAS_W-1:0] meas_count
);
  import baud_chain_pkg::*;

  samp_src_e src;
  assign src = samp_src_e'(samp_sel);

  baud_tick_divider #(.W(1)) u_proto (
    .clk(clk), .rst_n(rst_n), .en(chain_en), .in_tick(ref_tick),
    .ratio(half_sel), .out_tick(proto_tick));

  baud_tick_divider #(.W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .en(chain_en), .in_tick(proto_tick),
    .ratio(div_ratio), .out_tick(div_tick));

  assign samp_tick = chain_en &&
                     pick_sample(src, div_tick, proto_tick, sclk_tick, ref_tick);

  baud_tick_divider #(.W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(chain_en), .in_tick(samp_tick),
    .ratio(pre_ratio), .out_tick(pre_tick));

  baud_tick_divider #(.W(DEN_W)) u_den (
    .clk(clk), .rst_n(rst_n), .en(chain_en), .in_tick(pre_tick),
    .ratio(den_ratio), .out_tick(bit_tick));

  baud_meas_counter #(.W(MEAS_W)) u_meas (
    .clk(clk), .rst_n(rst_n), .en(chain_en && meas_en), .src_sel(meas_sel),
    .prot_tick(proto_tick), .div_tick(div_tick), .count(meas_count));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chain_en |-> !(proto_tick || div_tick || samp_tick || pre_tick || bit_tick));
  // R4
  sclk_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_sel == 2'd2 && !sclk_tick) |-> !samp_tick);
  // R10
  chain_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> (pre_tick && samp_tick));
endmodule

// File: tb/baud_div_chain_test.sv
module baud_div_chain_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chain_en = 1'b0, ref_tick = 1'b0, sclk_tick = 1'b0, half_sel = 1'b0;
  logic [9:0] div_ratio = '0;
  logic [1:0] samp_sel = '0;
  logic [1:0] pre_ratio = '0;
  logic [4:0] den_ratio = '0;
  logic meas_en = 1'b0, meas_sel = 1'b0;
  logic proto_tick, div_tick, samp_tick, pre_tick, bit_tick;
  logic [9:0] meas_count;

  int vectors = 0, errors = 0;
  int cp, cd, cs, cpre, cb, first_proto, first_div;

  always #4 clk = ~clk;

  baud_div_chain uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic restart(input bit h, input int dv, input int src, input int pr,
                         input int dn, input bit men, input bit msrc);
    @(negedge clk);
    chain_en = 1'b0; ref_tick = 1'b1; sclk_tick = 1'b1;
    half_sel = h; div_ratio = 10'(dv); samp_sel = 2'(src);
    pre_ratio = 2'(pr); den_ratio = 5'(dn); meas_en = men; meas_sel = msrc;
    @(negedge clk); #1;
    // R1: disabled chain is silent
    chk({proto_tick, div_tick, samp_tick, pre_tick, bit_tick} == 5'b0 && meas_count == 0,
        "R1 idle", {proto_tick, div_tick, samp_tick, pre_tick, bit_tick}, 0);
    @(negedge clk);
    chain_en = 1'b1; ref_tick = 1'b0; sclk_tick = 1'b0;
  endtask

  task automatic run(input int n, input int rp, input int sp);
    cp = 0; cd = 0; cs = 0; cpre = 0; cb = 0; first_proto = -1; first_div = -1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ref_tick = (i % rp == 0); sclk_tick = (i % sp == 0);
      #1;
      if (proto_tick) begin cp++; if (first_proto < 0) first_proto = i; end
      if (div_tick) begin cd++; if (first_div < 0) first_div = i; end
      if (samp_tick) cs++;
      if (pre_tick) cpre++;
      if (bit_tick) cb++;
    end
    @(negedge clk); ref_tick = 1'b0; sclk_tick = 1'b0; #1;
  endtask

  task automatic t_basic;
    restart(0, 2, 0, 1, 2, 1, 0);
    run(60, 1, 1);
    chk(cp == 60, "R2 proto pass", cp, 60);
    chk(cd == 20, "R3 div by 3", cd, 20);
    chk(cs == 20, "R4 src div", cs, 20);
    chk(cpre == 10, "R5 pre by 2", cpre, 10);
    chk(cb == 3, "R6 den by 3", cb, 3);
    chk(meas_count == 60, "R9 meas proto", meas_count, 60);
  endtask

  task automatic t_half;
    restart(1, 0, 1, 0, 0, 0, 0);
    run(40, 1, 1);
    chk(cp == 20, "R2 half rate", cp, 20);
    chk(first_proto == 1, "R2 first half tick", first_proto, 1);
    chk(cd == 20, "R8 div zero pass", cd, 20);
    chk(cs == 20, "R4 src proto", cs, 20);
    chk(cb == 20, "R8 den zero pass", cb, 20);
  endtask

  task automatic t_sclk;
    restart(0, 4, 2, 3, 0, 1, 1);
    run(30, 2, 3);
    chk(cp == 15, "R2 sparse ref", cp, 15);
    chk(cd == 3, "R3 div by 5", cd, 3);
    chk(cs == 10, "R4 src sclk", cs, 10);
    chk(cpre == 2, "R5 pre by 4", cpre, 2);
    chk(meas_count == 3, "R9 meas div", meas_count, 3);
  endtask

  task automatic t_ref;
    restart(1, 9, 3, 0, 15, 0, 0);
    run(50, 1, 1);
    chk(cd == 2, "R3 div by 10", cd, 2);
    chk(cs == 50, "R4 src ref", cs, 50);
    chk(cb == 3, "R6 den by 16", cb, 3);
  endtask

  task automatic t_change;
    int n = 0, first = -1;
    restart(0, 3, 0, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      ref_tick = 1'b1;
      if (i == 2) div_ratio = 10'd0;
      #1;
      if (div_tick) begin n++; if (first < 0) first = i; end
    end
    @(negedge clk); ref_tick = 1'b0;
    chk(first == 3, "R7 old ratio finishes", first, 3);
    chk(n == 5, "R7 new ratio after terminal", n, 5);
  endtask

  task automatic t_reenable;
    restart(0, 3, 0, 0, 0, 0, 0);
    run(2, 1, 1);
    @(negedge clk); chain_en = 1'b0;
    @(negedge clk); chain_en = 1'b1;
    run(4, 1, 1);
    chk(first_div == 3, "R1 restart from zero", first_div, 3);
    chk(cd == 1, "R1 one tick after restart", cd, 1);
  endtask

  task automatic t_wrap;
    restart(0, 0, 0, 0, 0, 1, 0);
    run(1030, 1, 1);
    chk(meas_count == 6, "R9 wrap", meas_count, 6);
    @(negedge clk); meas_en = 1'b0;
    @(negedge clk); #1;
    chk(meas_count == 0, "R9 clear", meas_count, 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk({proto_tick, div_tick, samp_tick, pre_tick, bit_tick} == 5'b0 && meas_count == 0,
        "R1 reset", meas_count, 0);
    rst_n = 1'b1;
    t_basic;
    t_half;
    t_sclk;
    t_ref;
    t_change;
    t_reenable;
    t_wrap;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule